// File: doc/BRIEF.md
# Level-Latched Interrupt Controller With Message Dispatch

This block gathers a small set of level-sensitive interrupt lines and keeps four views of them in registers: the live level of each line, a sticky record of lines that have risen, a per-line enable mask, and a per-line class bit. Software reads two combined request views, one for each class. Each view shows the lines that are currently high and enabled.

When an enabled line goes from low to high, the block places a posted write on a small outbound message port. There are two programmable dispatch registers, and the line's class bit picks one of them. The message address is the chosen register value with its low five bits cleared. The message data is those five bits.

If several lines rise at once, each one is queued and sent out in turn, lowest line first, one message per accepted transfer. The default line usage is as follows. Bits 0 to 5 are the six PCI interrupt pins A to F. Bit 6 is an external bus interrupt, bit 7 is a non-fatal bus error, bit 8 is the PS/2 controller, bit 9 is unused and bit 10 is a serial port.

Top module: `irq_msg_dispatch`

## Requirements
- R1: The level register (select 4) reads, zero-extended, the line inputs as sampled at the previous clock edge.
- R2: A pending bit (select 5) is set only when its line is high and its level bit is low. A line that stays high does not set it again.
- R3: Any read or any write of the pending register clears it at the next edge, whatever data is written. A rise in that same cycle still sets its bit.
- R4: Request view 0 (select 6) reads level AND mask AND NOT class. Request view 1 (select 7) reads level AND mask AND class. Writes to selects 4, 6 and 7 change nothing.
- R5: A rise on a line whose mask bit is set queues one message for that line. When the message is issued, it uses dispatch register 1 (select 3) if the line's class bit (select 1) is set, and dispatch register 0 (select 2) otherwise.
- R6: The message address is the chosen dispatch value with bits 4:0 cleared. The message data is bits 4:0 of that value, zero-extended to 32 bits.
- R7: After reset, both dispatch registers read 0xFFFB0003. Mask, class, level and pending read 0, and msgValid is low.
- R8: Queued lines are issued lowest index first, one per load. A line that rises again while it is still queued yields only one message.
- R9: While msgValid is high and msgReady is low, msgValid, msgAddr and msgData hold. A new message may load in the same cycle that the previous one is accepted.
- R10: Mask (select 0) and class (select 1) keep NUM_LINES bits, and their upper bits read 0. Reads are combinational on regSel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | NUM_LINES | Level-sensitive interrupt lines |
| regSel | input | 3 | Register select |
| regRd | input | 1 | Read strobe (clears pending when select 5) |
| regWr | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regSel |
| msgValid | output | 1 | Outbound message valid |
| msgReady | input | 1 | Outbound message accepted |
| msgAddr | output | 32 | Message target address |
| msgData | output | 32 | Message payload |

## Verification
The assertions assume the lines are synchronous to clk. They also assume that msgReady may be dropped at any time, including while a message is waiting. The stimulus drives every input just after the falling edge. It sweeps random line patterns, so several lines can rise in one cycle, lines can re-rise while still queued, and mask, class or dispatch can be written in the same cycle as a rise or a load. Reset is released between edges, so the past-value checks never see an undefined history.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

  localparam int IDX_W = 5;   // enough to index up to 32 lines

  typedef enum logic [2:0] {
    SEL_MASK  = 3'd0,
    SEL_CLASS = 3'd1,
    SEL_DISP0 = 3'd2,
    SEL_DISP1 = 3'd3,
    SEL_LEVEL = 3'd4,
    SEL_PEND  = 3'd5,
    SEL_VIEW0 = 3'd6,
    SEL_VIEW1 = 3'd7
  } regSel_e;

  typedef struct packed {
    logic             wrMask;
    logic             wrClass;
    logic             wrDisp0;
    logic             wrDisp1;
    logic             clrPend;
    logic             loadMsg;
    logic [IDX_W-1:0] grantIdx;
  } ctlStrb_t;

endpackage

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import irq_msg_pkg::*;
#(
  parameter int NUM_LINES = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           regSel,
  input  logic                 regRd,
  input  logic                 regWr,
  input  logic [NUM_LINES-1:0] captureVec,
  input  logic                 msgReady,
  output ctlStrb_t             strb,
  output logic                 msgValid
);

  logic [NUM_LINES-1:0] queue;
  logic [NUM_LINES-1:0] grantVec;
  logic [IDX_W-1:0]     grantIdx;
  logic                 loadOk;
  logic                 anyQueued;

  assign anyQueued = |queue;
  assign loadOk    = !msgValid || msgReady;

  // lowest set bit wins
  always_comb begin
    grantIdx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (queue[i]) grantIdx = IDX_W'(i);
    end
  end

  always_comb begin
    grantVec = '0;
    if (strb.loadMsg) grantVec[grantIdx] = 1'b1;
  end

  always_comb begin
    strb          = '0;
    strb.wrMask   = regWr && (regSel == SEL_MASK);
    strb.wrClass  = regWr && (regSel == SEL_CLASS);
    strb.wrDisp0  = regWr && (regSel == SEL_DISP0);
    strb.wrDisp1  = regWr && (regSel == SEL_DISP1);
    strb.clrPend  = (regWr || regRd) && (regSel == SEL_PEND);
    strb.loadMsg  = loadOk && anyQueued;
    strb.grantIdx = grantIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      queue    <= '0;
      msgValid <= 1'b0;
    end else begin
      queue <= (queue & ~grantVec) | captureVec;
      if (loadOk) msgValid <= anyQueued;
    end
  end

  logic [NUM_LINES-1:0] belowGrant;
  assign belowGrant = (NUM_LINES'(1) << grantIdx) - NUM_LINES'(1);

  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadMsg |-> (queue[grantIdx] && ((queue & belowGrant) == '0))); // R8

  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec)); // R8

  AST_QUEUE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(queue) & ~$past(grantVec) & ~queue) == '0)); // R8

  AST_CAPTURE_QUEUED: assert property (@(posedge clk) disable iff (!rstN)
    (captureVec != '0) |=> ((queue & $past(captureVec)) == $past(captureVec))); // R5

endmodule

// File: rtl/irq_msg_datapath.sv
module irq_msg_datapath
  import irq_msg_pkg::*;
#(
  parameter int          NUM_LINES  = 11,
  parameter int          DATA_W     = 32,
  parameter int          ALIGN_BITS = 5,
  parameter logic [31:0] DISP_RESET = 32'hFFFB_0003
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic [2:0]           regSel,
  input  logic [DATA_W-1:0]    regWdata,
  input  ctlStrb_t             strb,
  output logic [NUM_LINES-1:0] captureVec,
  output logic [DATA_W-1:0]    regRdata,
  output logic [DATA_W-1:0]    msgAddr,
  output logic [DATA_W-1:0]    msgData
);

  localparam int PAD_W = DATA_W - NUM_LINES;

  logic [NUM_LINES-1:0] levelReg, pendReg, maskReg, classReg;
  logic [DATA_W-1:0]    disp0Reg, disp1Reg;
  logic [NUM_LINES-1:0] riseVec;
  logic [DATA_W-1:0]    dispSel;

  assign riseVec    = lineIn & ~levelReg;
  assign captureVec = riseVec & maskReg;
  assign dispSel    = classReg[strb.grantIdx] ? disp1Reg : disp0Reg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelReg <= '0;
      pendReg  <= '0;
      maskReg  <= '0;
      classReg <= '0;
      disp0Reg <= DISP_RESET;
      disp1Reg <= DISP_RESET;
      msgAddr  <= '0;
      msgData  <= '0;
    end else begin
      levelReg <= lineIn;
      pendReg  <= (strb.clrPend ? '0 : pendReg) | riseVec;
      if (strb.wrMask)  maskReg  <= regWdata[NUM_LINES-1:0];
      if (strb.wrClass) classReg <= regWdata[NUM_LINES-1:0];
      if (strb.wrDisp0) disp0Reg <= regWdata;
      if (strb.wrDisp1) disp1Reg <= regWdata;
      if (strb.loadMsg) begin
        msgAddr <= {dispSel[DATA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        msgData <= {{(DATA_W-ALIGN_BITS){1'b0}}, dispSel[ALIGN_BITS-1:0]};
      end
    end
  end

  always_comb begin
    unique case (regSel_e'(regSel))
      SEL_MASK:  regRdata = {{PAD_W{1'b0}}, maskReg};
      SEL_CLASS: regRdata = {{PAD_W{1'b0}}, classReg};
      SEL_DISP0: regRdata = disp0Reg;
      SEL_DISP1: regRdata = disp1Reg;
      SEL_LEVEL: regRdata = {{PAD_W{1'b0}}, levelReg};
      SEL_PEND:  regRdata = {{PAD_W{1'b0}}, pendReg};
      SEL_VIEW0: regRdata = {{PAD_W{1'b0}}, levelReg & maskReg & ~classReg};
      SEL_VIEW1: regRdata = {{PAD_W{1'b0}}, levelReg & maskReg & classReg};
      default:   regRdata = '0;
    endcase
  end

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (levelReg == $past(lineIn))); // R1

  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrPend |=> ((pendReg & ~$past(lineIn)) == '0)); // R3

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrPend |=> ((($past(pendReg)) & ~pendReg) == '0)); // R2

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendReg & ~$past(pendReg) & $past(levelReg)) == '0)); // R2

endmodule

// File: rtl/irq_msg_dispatch.sv
module irq_msg_dispatch
  import irq_msg_pkg::*;
#(
  parameter int          NUM_LINES  = 11,
  parameter int          DATA_W     = 32,
  parameter int          ALIGN_BITS = 5,
  parameter logic [31:0] DISP_RESET = 32'hFFFB_0003
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic [2:0]           regSel,
  input  logic                 regRd,
  input  logic                 regWr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 msgValid,
  input  logic                 msgReady,
  output logic [DATA_W-1:0]    msgAddr,
  output logic [DATA_W-1:0]    msgData
);

  ctlStrb_t             strb;
  logic [NUM_LINES-1:0] captureVec;

  irq_msg_ctrl #(
    .NUM_LINES (NUM_LINES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regSel     (regSel),
    .regRd      (regRd),
    .regWr      (regWr),
    .captureVec (captureVec),
    .msgReady   (msgReady),
    .strb       (strb),
    .msgValid   (msgValid)
  );

  irq_msg_datapath #(
    .NUM_LINES  (NUM_LINES),
    .DATA_W     (DATA_W),
    .ALIGN_BITS (ALIGN_BITS),
    .DISP_RESET (DISP_RESET)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .lineIn     (lineIn),
    .regSel     (regSel),
    .regWdata   (regWdata),
    .strb       (strb),
    .captureVec (captureVec),
    .regRdata   (regRdata),
    .msgAddr    (msgAddr),
    .msgData    (msgData)
  );

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgAddr) && $stable(msgData))); // R9

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgAddr[ALIGN_BITS-1:0] == '0)); // R6

  AST_DATA_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgData[DATA_W-1:ALIGN_BITS] == '0)); // R6

endmodule

// File: tb/irq_msg_dispatch_tb.sv
module irq_msg_dispatch_tb;

  localparam int NL = 11;
  localparam realtime HALF = 2.5ns;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL-1:0] lineIn = '0;
  logic [2:0]    regSel = '0;
  logic          regRd = 1'b0, regWr = 1'b0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata;
  logic          msgValid, msgReady = 1'b1;
  logic [31:0]   msgAddr, msgData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #HALF clk = ~clk;

  irq_msg_dispatch u_dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .regSel(regSel), .regRd(regRd),
    .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata), .msgValid(msgValid),
    .msgReady(msgReady), .msgAddr(msgAddr), .msgData(msgData)
  );

  // behavioural reference state
  bit [NL-1:0] mLevel, mPend, mMask, mClass;
  bit [31:0]   mD0, mD1, mAddr, mData;
  bit          mValid;
  int          waitList[$];   // line indices queued for a message, ascending

  function automatic string tagFor(input int sel);
    case (sel)
      0, 1:    return "R10";
      2, 3:    return "R7";
      4:       return "R1";
      5:       return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic bit [31:0] modelRead(input int sel);
    case (sel)
      0: return 32'(mMask);
      1: return 32'(mClass);
      2: return mD0;
      3: return mD1;
      4: return 32'(mLevel);
      5: return 32'(mPend);
      6: return 32'(mLevel & mMask & ~mClass);
      default: return 32'(mLevel & mMask & mClass);
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mLevel = '0; mPend = '0; mMask = '0; mClass = '0;
    mD0 = 32'hFFFB0003; mD1 = 32'hFFFB0003;
    mAddr = '0; mData = '0; mValid = 0;
    waitList.delete();
  endtask

  task automatic modelEdge();
    bit [NL-1:0] rise, nPend;
    bit [31:0]   pick;
    bit          inList;
    rise  = lineIn & ~mLevel;
    nPend = (((regRd || regWr) && regSel == 3'd5) ? '0 : mPend) | rise;
    if (!mValid || msgReady) begin
      if (waitList.size() > 0) begin
        pick   = mClass[waitList[0]] ? mD1 : mD0;
        mAddr  = pick & ~32'h1F;
        mData  = pick & 32'h1F;
        mValid = 1;
        void'(waitList.pop_front());
      end else mValid = 0;
    end
    for (int i = 0; i < NL; i++) begin
      if (rise[i] && mMask[i]) begin
        inList = 0;
        foreach (waitList[k]) if (waitList[k] == i) inList = 1;
        if (!inList) waitList.push_back(i);
      end
    end
    waitList.sort();
    if (regWr) begin
      case (regSel)
        3'd0: mMask  = regWdata[NL-1:0];
        3'd1: mClass = regWdata[NL-1:0];
        3'd2: mD0    = regWdata;
        3'd3: mD1    = regWdata;
        default: ;
      endcase
    end
    mLevel = lineIn;
    mPend  = nPend;
  endtask

  // drive after falling edge, compare, then advance one clock
  task automatic step(input logic [NL-1:0] l, input int sel, input bit rd, input bit wr,
                      input logic [31:0] wd, input bit rdy);
    lineIn = l; regSel = 3'(sel); regRd = rd; regWr = wr; regWdata = wd; msgReady = rdy;
    #1;
    check("R5", "msgValid", 32'(msgValid), 32'(mValid));
    if (mValid) begin
      check("R6", "msgAddr", msgAddr, mAddr);
      check("R6", "msgData", msgData, mData);
    end
    check(tagFor(sel), "regRdata", regRdata, modelRead(sel));
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit rdy);
    for (int i = 0; i < n; i++) step(lineIn, 4, 0, 0, 0, rdy);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R7: reset state
    for (int s = 0; s < 8; s++) step('0, s, 0, 0, 0, 1);

    // program mask all, class bit 5, two dispatch targets
    step('0, 0, 0, 1, 32'h7FF, 1);
    step('0, 1, 0, 1, 32'h20, 1);
    step('0, 2, 0, 1, 32'h1234_5675, 1);
    step('0, 3, 0, 1, 32'hABCD_EF1F, 1);

    // R8: three lines rise together, issued 2,5,9 with class picking target
    step(11'h224, 6, 0, 0, 0, 1);
    step(11'h224, 7, 0, 0, 0, 1);
    a0 = msgAddr;
    check("R8", "first message line2 via dispatch0", a0, 32'h1234_5660);
    step(11'h224, 5, 0, 0, 0, 1);
    check("R8", "second message line5 via dispatch1", msgAddr, 32'hABCD_EF00);
    check("R6", "second message data", msgData, 32'h1F);
    // R2: lines held high, pending read clears and is not re-set
    step(11'h224, 5, 1, 0, 0, 1);
    step(11'h224, 5, 0, 0, 0, 1);
    check("R2", "pending stays clear while high", regRdata, 32'h0);
    step('0, 4, 0, 0, 0, 1);

    // R9: backpressure
    step(11'h003, 4, 0, 0, 0, 0);
    idle(4, 0);
    check("R9", "held valid", 32'(msgValid), 32'h1);
    idle(4, 1);

    // R4: writes to read-only registers ignored
    step(11'h0F0, 4, 0, 1, 32'hFFFF_FFFF, 1);
    step(11'h0F0, 6, 0, 1, 32'hFFFF_FFFF, 1);
    step(11'h0F0, 7, 0, 1, 32'hFFFF_FFFF, 1);
    step(11'h0F0, 4, 0, 0, 0, 1);
    check("R4", "level after write attempt", regRdata, 32'h0F0);
    // R3: write clears pending
    step(11'h0F0, 5, 0, 1, 32'h0, 1);
    step(11'h0F0, 5, 0, 0, 0, 1);
    check("R3", "pending after write", regRdata, 32'h0);
    idle(6, 1);

    // random phase, compared to model every cycle
    for (int n = 0; n < 3000; n++) begin
      int          s;
      bit          rd, wr;
      logic [31:0] wd;
      s  = $urandom_range(0, 7);
      rd = ($urandom_range(0, 3) == 0);
      wr = ($urandom_range(0, 5) == 0);
      wd = $urandom();
      step(NL'($urandom()) & NL'($urandom()), s, rd, wr, wd, ($urandom_range(0, 9) < 7));
    end
    idle(20, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule